// File: doc/BRIEF.md
# Battery-Backed Key Register Controller

This block is a 32-bit word-addressed register port that guards a nine-word secret key. The key lives in storage that only the power-on reset input clears, so an ordinary reset of the surrounding logic leaves it in place. Software can write the key words but never read the eight main words back. Programming is allowed only after a fixed unlock code has been written, and that unlock lasts until the next power-on reset. Writing the unlock code also wipes the key. A control bit wipes the key on demand, and a status flag reports when the key has been wiped and not yet rewritten with a nonzero word.

Software checks that the key was loaded correctly by writing an expected checksum. The block then runs a reflected CRC-32C over one zero word followed by main words 0 to 7, one word per clock. When the last word has been processed it raises a done flag and a pass flag together. The ninth word has its own rules, chosen by a parameter. In the write-only variant it reads as zero, is wiped along with the others and cannot be locked. In the readable variant it reads back, survives a wipe and can be frozen by a sticky lock bit. Accesses to holes in the map raise one maskable interrupt source and, when enabled, a slave-error response.

Top module: `kv_key_vault`

## Requirements
- R1: The register at byte offset 0x00 reads {pass at bit 9, done at bit 8, zeroized at bit 4, programming mode at bit 0}, with all other bits 0. Writes to it have no effect.
- R2: A write of exactly 0x757BDF0D to offset 0x08 sets programming mode and wipes the key. A write of any other value changes nothing. Offset 0x08 reads 0.
- R3: Programming mode stays set through ordinary reset and is cleared only by the power-on reset. Ordinary reset leaves the key words, the lock and the zeroized flag unchanged. It restores the slave-error enable to 0, the interrupt status to 0, the mask to 1, and done and pass to 0.
- R4: A write with bit 0 set to offset 0x04 wipes the key at any time. Offset 0x04 always reads 0.
- R5: Writes to main words 0–7 (offsets 0x10–0x2C) are dropped outside programming mode. Those offsets and the expected-CRC offset 0x0C read 0.
- R6: A write to word 8 (offset 0x30) takes effect only when programming mode is set and the lock is clear. Word 8 reads 0 in the write-only variant and reads its stored value in the readable variant.
- R7: Writing 1 to bit 0 of offset 0x4C sets the lock, which stays set until power-on reset. Writing 0 does not clear it. In the write-only variant the lock never sets. The lock reads back in bit 0.
- R8: A wipe clears main words 0–7, also clears word 8 in the write-only variant only, and sets the zeroized flag. An accepted nonzero write to a main word clears the flag. An accepted nonzero write to word 8 clears it in the write-only variant only.
- R9: A write to 0x0C in programming mode with no check running starts a check. Nine cycles later, done goes to 1 and pass is set to whether the written value equals the inverted reflected CRC-32C (polynomial 0x82F63B78, initial value all ones) of a zero word followed by words 0–7, each word taken least significant byte first.
- R10: A write to 0x0C outside programming mode, or while a check is running, is ignored. A main-word write made during a check is held and applied in the first cycle after the check ends, and a later held write replaces an earlier one.
- R11: Any access to an unmapped or unaligned address sets interrupt status bit 0 (offset 0x38, write 1 to clear). The slave-error output is high during that access when bit 0 of 0x34 is set. A 1 written to 0x40 clears the mask (0x3C, read-only) and a 1 written to 0x44 sets it; both of those offsets read 0. The interrupt output is status AND NOT mask.
- R12: The power-on reset clears all key words, programming mode, the lock and the zeroized flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Ordinary reset, active low, asynchronous; keeps the key |
| por_n | input | 1 | Power-on reset, active low, asynchronous; clears everything |
| bus_wr | input | 1 | Write strobe, one word per cycle |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as the address |
| bus_slverr | output | 1 | Slave-error response for an access to a hole in the map |
| irq | output | 1 | Interrupt: status AND NOT mask |

## Verification
Two instances share one bus, one in the write-only variant and one in the readable variant, so every stimulus also shows where the word-8 rules diverge. The integrity check is run against a key loaded with distinct words and against an all-zero key after a wipe, each time once with the correct checksum and once with a wrong one; this separates a correct CRC from a mismatch that merely happens to report. A key write is issued while a check is running together with a second checksum write. If the held write leaked in early, or if the second start were obeyed, the pass result of that check would flip. Writes outside programming mode, after locking and across ordinary reset are shown through the zeroized flag, the readable word 8 and a later check pass.

// File: rtl/kv_pkg.sv
package kv_pkg;

  localparam int unsigned KV_MAIN_WORDS = 8;
  localparam logic [31:0] KV_UNLOCK_CODE = 32'h757B_DF0D;
  localparam logic [31:0] KV_CRC_POLY = 32'h82F6_3B78;

  // word indices (byte offset / 4)
  localparam int unsigned KV_IX_STATUS = 0;
  localparam int unsigned KV_IX_CTRL = 1;
  localparam int unsigned KV_IX_UNLOCK = 2;
  localparam int unsigned KV_IX_CRC = 3;
  localparam int unsigned KV_IX_KEY0 = 4;
  localparam int unsigned KV_IX_ERREN = 13;
  localparam int unsigned KV_IX_ISR = 14;
  localparam int unsigned KV_IX_IMR = 15;
  localparam int unsigned KV_IX_IER = 16;
  localparam int unsigned KV_IX_IDR = 17;
  localparam int unsigned KV_IX_LOCK = 19;

  // status bit positions
  localparam int unsigned KV_ST_PGM = 0;
  localparam int unsigned KV_ST_ZERO = 4;
  localparam int unsigned KV_ST_DONE = 8;
  localparam int unsigned KV_ST_PASS = 9;

  // one 32-bit word through a reflected CRC, bit 0 first
  function automatic logic [31:0] kv_crc_step(input logic [31:0] acc, input logic [31:0] word);
    logic [31:0] c;
    c = acc ^ word;
    for (int b = 0; b < 32; b++) begin
      c = c[0] ? ((c >> 1) ^ KV_CRC_POLY) : (c >> 1);
    end
    return c;
  endfunction

endpackage

// File: rtl/kv_crc_seq.sv
module kv_crc_seq #(
  parameter int unsigned NMAIN = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_i,
  input  logic [31:0]           expect_i,
  input  logic [NMAIN-1:0][31:0] keys_i,
  output logic                  busy_o,
  output logic                  fin_o,
  output logic                  pass_o
);
  import kv_pkg::*;

  localparam int unsigned CW = $clog2(NMAIN + 1);
  localparam int unsigned IW = $clog2(NMAIN);
  localparam logic [CW-1:0] LAST = CW'(NMAIN);

  logic [CW-1:0] step_q;
  logic [31:0]   acc_q, expect_q, word, acc_nxt;
  logic          busy_q;

  // step 0 feeds the zero pad word, step k feeds main word k-1
  always_comb begin
    word    = (step_q == '0) ? 32'h0 : keys_i[IW'(step_q - 1'b1)];
    acc_nxt = kv_crc_step(acc_q, word);
  end

  assign busy_o = busy_q;
  assign fin_o  = busy_q && (step_q == LAST);
  assign pass_o = (~acc_nxt == expect_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      step_q   <= '0;
      acc_q    <= '1;
      expect_q <= '0;
    end else if (busy_q) begin
      acc_q <= acc_nxt;
      if (fin_o) busy_q <= 1'b0;
      else       step_q <= step_q + 1'b1;
    end else if (start_i) begin
      busy_q   <= 1'b1;
      step_q   <= '0;
      acc_q    <= '1;
      expect_q <= expect_i;
    end
  end

  assert_start_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_q) |=> busy_q);
  assert_fin_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fin_o |=> !busy_q);
  assert_step_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (step_q <= LAST));
  assert_no_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !fin_o) |=> (step_q != '0));

endmodule

// File: rtl/kv_keystore.sv
module kv_keystore #(
  parameter int unsigned NMAIN = 8,
  parameter bit          W8_WO = 1'b1,
  localparam int unsigned IW   = $clog2(NMAIN)
) (
  input  logic                   clk,
  input  logic                   por_n,
  input  logic                   pgm_i,
  input  logic                   busy_i,
  input  logic                   wr_main_i,
  input  logic [IW-1:0]          wr_idx_i,
  input  logic [31:0]            wr_data_i,
  input  logic                   wr_w8_i,
  input  logic                   w8_allow_i,
  input  logic                   zeroize_i,
  output logic [NMAIN-1:0][31:0] main_o,
  output logic [31:0]            w8_o,
  output logic                   zeroed_o
);

  logic [NMAIN-1:0][31:0] main_q;
  logic [31:0]            w8_q, pend_data;
  logic [IW-1:0]          pend_idx;
  logic                   pend_v, zeroed_q;
  logic                   take_pend, direct, defer, w8_take, nz_hit;

  always_comb begin
    take_pend = pend_v && !busy_i;
    direct    = wr_main_i && pgm_i && !busy_i;
    defer     = wr_main_i && pgm_i && busy_i;
    w8_take   = wr_w8_i && w8_allow_i;
    nz_hit    = (take_pend && (pend_data != '0)) ||
                (direct && (wr_data_i != '0)) ||
                (W8_WO && w8_take && (wr_data_i != '0));
  end

  // priority: held write, then new write, then wipe
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      main_q    <= '0;
      w8_q      <= '0;
      pend_v    <= 1'b0;
      pend_idx  <= '0;
      pend_data <= '0;
      zeroed_q  <= 1'b0;
    end else begin
      if (take_pend) main_q[pend_idx] <= pend_data;
      if (direct)    main_q[wr_idx_i] <= wr_data_i;
      if (w8_take)   w8_q <= wr_data_i;
      if (defer) begin
        pend_v    <= 1'b1;
        pend_idx  <= wr_idx_i;
        pend_data <= wr_data_i;
      end else if (take_pend) begin
        pend_v <= 1'b0;
      end
      if (zeroize_i) begin
        main_q <= '0;
        if (W8_WO) w8_q <= '0;
      end
      if (zeroize_i)   zeroed_q <= 1'b1;
      else if (nz_hit) zeroed_q <= 1'b0;
    end
  end

  assign main_o   = main_q;
  assign w8_o     = w8_q;
  assign zeroed_o = zeroed_q;

  assert_drop_R5: assert property (@(posedge clk) disable iff (!por_n)
    (wr_main_i && !pgm_i && !pend_v && !zeroize_i) |=> $stable(main_q));
  assert_w8_hold_R6: assert property (@(posedge clk) disable iff (!por_n)
    (wr_w8_i && !w8_allow_i && !zeroize_i) |=> $stable(w8_q));
  assert_wipe_R8: assert property (@(posedge clk) disable iff (!por_n)
    zeroize_i |=> (zeroed_q && (main_q == '0)));
  assert_hold_R10: assert property (@(posedge clk) disable iff (!por_n)
    (busy_i && !zeroize_i) |=> $stable(main_q));

endmodule

// File: rtl/kv_irq.sv
module kv_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic err_i,
  input  logic clr_i,
  input  logic unmask_i,
  input  logic mask_i,
  output logic isr_o,
  output logic imr_o,
  output logic irq_o
);

  logic isr_q, imr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      isr_q <= 1'b0;
      imr_q <= 1'b1;
    end else begin
      if (err_i)      isr_q <= 1'b1;
      else if (clr_i) isr_q <= 1'b0;
      if (unmask_i)    imr_q <= 1'b0;
      else if (mask_i) imr_q <= 1'b1;
    end
  end

  assign isr_o = isr_q;
  assign imr_o = imr_q;
  assign irq_o = isr_q & ~imr_q;

  assert_err_latch_R11: assert property (@(posedge clk) disable iff (!rst_n)
    err_i |=> isr_q);
  assert_unmask_R11: assert property (@(posedge clk) disable iff (!rst_n)
    unmask_i |=> !imr_q);

endmodule

// File: rtl/kv_key_vault.sv
module kv_key_vault #(
  parameter int unsigned ADDR_W = 7,
  parameter bit          W8_WO  = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              por_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_slverr,
  output logic              irq
);
  import kv_pkg::*;

  localparam int unsigned NMAIN = KV_MAIN_WORDS;
  localparam int unsigned IW    = $clog2(NMAIN);
  localparam int unsigned RIW   = ADDR_W - 2;
  localparam logic [RIW-1:0] A_STATUS = RIW'(KV_IX_STATUS);
  localparam logic [RIW-1:0] A_CTRL   = RIW'(KV_IX_CTRL);
  localparam logic [RIW-1:0] A_UNLOCK = RIW'(KV_IX_UNLOCK);
  localparam logic [RIW-1:0] A_CRC    = RIW'(KV_IX_CRC);
  localparam logic [RIW-1:0] A_KEY0   = RIW'(KV_IX_KEY0);
  localparam logic [RIW-1:0] A_KEY8   = RIW'(KV_IX_KEY0 + NMAIN);
  localparam logic [RIW-1:0] A_ERREN  = RIW'(KV_IX_ERREN);
  localparam logic [RIW-1:0] A_ISR    = RIW'(KV_IX_ISR);
  localparam logic [RIW-1:0] A_IMR    = RIW'(KV_IX_IMR);
  localparam logic [RIW-1:0] A_IER    = RIW'(KV_IX_IER);
  localparam logic [RIW-1:0] A_IDR    = RIW'(KV_IX_IDR);
  localparam logic [RIW-1:0] A_LOCK   = RIW'(KV_IX_LOCK);

  logic                   sys_rst_n;
  logic [RIW-1:0]         ridx;
  logic                   aligned, access, mapped, wr_hit, is_main;
  logic                   unlock_hit, zeroize, crc_start, err_ev;
  logic                   pgm_q, lock_q, slv_en_q, done_q, pass_q;
  logic                   busy, fin, pass_now, isr, imr, st_zeroed;
  logic [NMAIN-1:0][31:0] main_keys;
  logic [31:0]            w8, w8_rd;

  assign sys_rst_n = rst_n & por_n;

  // decode
  always_comb begin
    ridx       = bus_addr[ADDR_W-1:2];
    aligned    = (bus_addr[1:0] == 2'b00);
    access     = bus_wr | bus_rd;
    mapped     = aligned && ((ridx <= A_IDR) || (ridx == A_LOCK));
    wr_hit     = bus_wr && aligned;
    is_main    = (ridx >= A_KEY0) && (ridx < A_KEY8);
    unlock_hit = wr_hit && (ridx == A_UNLOCK) && (bus_wdata == KV_UNLOCK_CODE);
    zeroize    = unlock_hit || (wr_hit && (ridx == A_CTRL) && bus_wdata[0]);
    crc_start  = wr_hit && (ridx == A_CRC) && pgm_q;
    err_ev     = access && !mapped;
  end

  // state kept through ordinary reset
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      pgm_q  <= 1'b0;
      lock_q <= 1'b0;
    end else begin
      if (unlock_hit) pgm_q <= 1'b1;
      if (wr_hit && (ridx == A_LOCK) && bus_wdata[0] && !W8_WO) lock_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge sys_rst_n) begin
    if (!sys_rst_n) begin
      slv_en_q <= 1'b0;
      done_q   <= 1'b0;
      pass_q   <= 1'b0;
    end else begin
      if (wr_hit && (ridx == A_ERREN)) slv_en_q <= bus_wdata[0];
      if (fin) begin
        done_q <= 1'b1;
        pass_q <= pass_now;
      end
    end
  end

  kv_keystore #(.NMAIN(NMAIN), .W8_WO(W8_WO)) u_store (
    .clk       (clk),
    .por_n     (por_n),
    .pgm_i     (pgm_q),
    .busy_i    (busy),
    .wr_main_i (wr_hit && is_main),
    .wr_idx_i  (IW'(ridx - A_KEY0)),
    .wr_data_i (bus_wdata),
    .wr_w8_i   (wr_hit && (ridx == A_KEY8)),
    .w8_allow_i(pgm_q && !lock_q),
    .zeroize_i (zeroize),
    .main_o    (main_keys),
    .w8_o      (w8),
    .zeroed_o  (st_zeroed)
  );

  kv_crc_seq #(.NMAIN(NMAIN)) u_crc (
    .clk     (clk),
    .rst_n   (sys_rst_n),
    .start_i (crc_start),
    .expect_i(bus_wdata),
    .keys_i  (main_keys),
    .busy_o  (busy),
    .fin_o   (fin),
    .pass_o  (pass_now)
  );

  kv_irq u_irq (
    .clk     (clk),
    .rst_n   (sys_rst_n),
    .err_i   (err_ev),
    .clr_i   (wr_hit && (ridx == A_ISR) && bus_wdata[0]),
    .unmask_i(wr_hit && (ridx == A_IER) && bus_wdata[0]),
    .mask_i  (wr_hit && (ridx == A_IDR) && bus_wdata[0]),
    .isr_o   (isr),
    .imr_o   (imr),
    .irq_o   (irq)
  );

  generate
    if (W8_WO) begin : g_w8_hidden
      assign w8_rd = '0;
    end else begin : g_w8_visible
      assign w8_rd = w8;
    end
  endgenerate

  always_comb begin
    bus_rdata = '0;
    if (aligned) begin
      case (ridx)
        A_STATUS: begin
          bus_rdata[KV_ST_PASS] = pass_q;
          bus_rdata[KV_ST_DONE] = done_q;
          bus_rdata[KV_ST_ZERO] = st_zeroed;
          bus_rdata[KV_ST_PGM]  = pgm_q;
        end
        A_KEY8:  bus_rdata = w8_rd;
        A_ERREN: bus_rdata[0] = slv_en_q;
        A_ISR:   bus_rdata[0] = isr;
        A_IMR:   bus_rdata[0] = imr;
        A_LOCK:  bus_rdata[0] = lock_q;
        default: bus_rdata = '0;
      endcase
    end
  end

  assign bus_slverr = err_ev && slv_en_q;

  assert_unlock_R2: assert property (@(posedge clk) disable iff (!por_n)
    unlock_hit |=> (pgm_q && st_zeroed));
  assert_pgm_sticky_R3: assert property (@(posedge clk) disable iff (!por_n)
    pgm_q |=> pgm_q);
  assert_lock_sticky_R7: assert property (@(posedge clk) disable iff (!por_n)
    lock_q |=> lock_q);
  assert_lock_variant_R7: assert property (@(posedge clk) disable iff (!por_n)
    (wr_hit && (ridx == A_LOCK) && bus_wdata[0]) |=> (lock_q != W8_WO));
  assert_done_R9: assert property (@(posedge clk) disable iff (!sys_rst_n)
    fin |=> done_q);
  assert_crc_gate_R10: assert property (@(posedge clk) disable iff (!sys_rst_n)
    (wr_hit && (ridx == A_CRC) && !pgm_q && !busy) |=> !busy);

endmodule

// File: tb/kv_key_vault_tb.sv
`timescale 1ns/1ps
module kv_key_vault_tb;

  localparam logic [31:0] MAGIC = 32'h757B_DF0D;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0, por_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [6:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] rd0, rd1;
  logic        se0, se1, irq0, irq1;

  always #2 clk = ~clk;

  kv_key_vault #(.ADDR_W(7), .W8_WO(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .por_n(por_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rd0), .bus_slverr(se0), .irq(irq0));

  kv_key_vault #(.ADDR_W(7), .W8_WO(1'b0)) u_dut_rw (
    .clk(clk), .rst_n(rst_n), .por_n(por_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rd1), .bus_slverr(se1), .irq(irq1));

  // reference model, index 0 = write-only word 8, index 1 = readable word 8
  logic [31:0] mk [2][9];
  bit          mpgm[2], mlock[2], mzero[2], mdone[2], mpass[2], misr[2], mimr[2], men[2];
  int          mcnt[2];
  logic [31:0] mexp[2];
  bit          mpv[2];
  int          mpi[2];
  logic [31:0] mpd[2];

  int nchk = 0, nerr = 0, cyc = 0;

  function automatic bit is_mapped(logic [6:0] a);
    int ix;
    ix = int'(a[6:2]);
    return (a[1:0] == 2'b00) && ((ix <= 17) || (ix == 19));
  endfunction

  function automatic logic [31:0] bench_crc(int c);
    logic [31:0] crc, w;
    crc = 32'hFFFF_FFFF;
    for (int n = 0; n < 9; n++) begin
      w = (n == 0) ? 32'h0 : mk[c][n-1];
      for (int by = 0; by < 4; by++) begin
        crc = crc ^ {24'h0, w[8*by +: 8]};
        for (int k = 0; k < 8; k++)
          crc = crc[0] ? ((crc >> 1) ^ 32'h82F6_3B78) : (crc >> 1);
      end
    end
    return ~crc;
  endfunction

  function automatic logic [31:0] mread(int c, logic [6:0] a);
    if (a[1:0] != 2'b00) return 32'h0;
    case (int'(a[6:2]))
      0:  return {22'h0, mpass[c], mdone[c], 3'b0, mzero[c], 3'b0, mpgm[c]};
      12: return (c == 0) ? 32'h0 : mk[c][8];
      13: return {31'h0, men[c]};
      14: return {31'h0, misr[c]};
      15: return {31'h0, mimr[c]};
      19: return {31'h0, mlock[c]};
      default: return 32'h0;
    endcase
  endfunction

  function automatic string req_of(logic [6:0] a);
    if (!is_mapped(a)) return "R11";
    case (int'(a[6:2]))
      0: return "R1";
      1: return "R4";
      2: return "R2";
      12: return "R6";
      19: return "R7";
      13, 14, 15, 16, 17: return "R11";
      default: return "R5";
    endcase
  endfunction

  task automatic m_wipe(int c);
    for (int i = 0; i < 8; i++) mk[c][i] = 32'h0;
    if (c == 0) mk[c][8] = 32'h0;
    mzero[c] = 1'b1;
  endtask

  // model step on each rising edge
  always @(posedge clk) begin
    for (int c = 0; c < 2; c++) begin
      if (!por_n) begin
        for (int i = 0; i < 9; i++) mk[c][i] = 32'h0;
        mpgm[c] = 0; mlock[c] = 0; mzero[c] = 0;
        mdone[c] = 0; mpass[c] = 0; misr[c] = 0; mimr[c] = 1; men[c] = 0;
        mcnt[c] = 0; mexp[c] = 0; mpv[c] = 0; mpi[c] = 0; mpd[c] = 0;
      end else if (!rst_n) begin
        mdone[c] = 0; mpass[c] = 0; misr[c] = 0; mimr[c] = 1; men[c] = 0;
        mcnt[c] = 0; mexp[c] = 0;
      end else begin
        int was;
        int ix;
        was = mcnt[c];
        ix = int'(bus_addr[6:2]);
        if (was > 0) begin
          mcnt[c] = was - 1;
          if (mcnt[c] == 0) begin
            mdone[c] = 1;
            mpass[c] = (mexp[c] == bench_crc(c));
          end
        end
        if (was == 0 && mpv[c]) begin
          mk[c][mpi[c]] = mpd[c];
          if (mpd[c] != 0) mzero[c] = 0;
          mpv[c] = 0;
        end
        if ((bus_rd || bus_wr) && !is_mapped(bus_addr)) misr[c] = 1;
        if (bus_wr && bus_addr[1:0] == 2'b00) begin
          if (ix == 1 && bus_wdata[0]) m_wipe(c);
          if (ix == 2 && bus_wdata == MAGIC) begin m_wipe(c); mpgm[c] = 1; end
          if (ix == 3 && mpgm[c] && was == 0) begin mcnt[c] = 9; mexp[c] = bus_wdata; end
          if (ix >= 4 && ix <= 11 && mpgm[c]) begin
            if (was > 0) begin
              mpv[c] = 1; mpi[c] = ix - 4; mpd[c] = bus_wdata;
            end else begin
              mk[c][ix-4] = bus_wdata;
              if (bus_wdata != 0) mzero[c] = 0;
            end
          end
          if (ix == 12 && mpgm[c] && !mlock[c]) begin
            mk[c][8] = bus_wdata;
            if (c == 0 && bus_wdata != 0) mzero[c] = 0;
          end
          if (ix == 13) men[c] = bus_wdata[0];
          if (ix == 14 && bus_wdata[0]) misr[c] = 0;
          if (ix == 16 && bus_wdata[0]) mimr[c] = 0;
          if (ix == 17 && bus_wdata[0]) mimr[c] = 1;
          if (ix == 19 && c == 1 && bus_wdata[0]) mlock[c] = 1;
        end
      end
    end
  end

  task automatic chk(bit ok, string req, string what, logic [31:0] got, logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: got %h expected %h at %0t", req, what, got, exp, $time);
    end
  endtask

  // compare outputs with the model every cycle, away from the edge
  always @(negedge clk) begin
    #1;
    if (por_n && rst_n) begin
      logic [31:0] rdv [2];
      logic        irqv[2], sev[2];
      rdv[0] = rd0; rdv[1] = rd1; irqv[0] = irq0; irqv[1] = irq1; sev[0] = se0; sev[1] = se1;
      for (int c = 0; c < 2; c++) begin
        bit se_exp;
        se_exp = (bus_rd || bus_wr) && !is_mapped(bus_addr) && men[c];
        chk(irqv[c] == (misr[c] && !mimr[c]), "R11", "irq", {31'h0, irqv[c]},
            {31'h0, misr[c] && !mimr[c]});
        chk(sev[c] == se_exp, "R11", "slverr", {31'h0, sev[c]}, {31'h0, se_exp});
        if (bus_rd)
          chk(rdv[c] == mread(c, bus_addr), req_of(bus_addr),
              $sformatf("read cfg%0d addr %h", c, bus_addr), rdv[c], mread(c, bus_addr));
      end
    end
  end

  task automatic summary();
    $display("%0d/%0d checks passed", nchk - nerr, nchk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      nchk++; nerr++;
      $display("FAIL R9 watchdog: got %0d cycles expected below 50000", cyc);
      summary();
      $finish;
    end
  end

  task automatic wr(logic [6:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1; bus_rd = 0; bus_addr = a; bus_wdata = d;
  endtask

  task automatic rd(logic [6:0] a);
    @(negedge clk);
    bus_wr = 0; bus_rd = 1; bus_addr = a; bus_wdata = 32'h0;
  endtask

  task automatic idle(int n);
    repeat (n) begin
      @(negedge clk);
      bus_wr = 0; bus_rd = 0; bus_addr = '0; bus_wdata = '0;
    end
  endtask

  task automatic read_all();
    foreach (mk[0][i]) rd(7'(16 + 4 * i));
    rd(7'h00); rd(7'h04); rd(7'h08); rd(7'h0C);
    rd(7'h34); rd(7'h38); rd(7'h3C); rd(7'h40); rd(7'h44); rd(7'h4C);
    idle(1);
  endtask

  task automatic power_on();
    @(negedge clk);
    por_n = 0; rst_n = 0; bus_wr = 0; bus_rd = 0;
    repeat (3) @(negedge clk);
    por_n = 1; rst_n = 1;
  endtask

  task automatic load_keys(logic [31:0] seed);
    for (int i = 0; i < 8; i++) wr(7'(16 + 4 * i), seed * (i + 3) ^ 32'h5A00_0000);
  endtask

  initial begin
    // R12: power-on state
    power_on();
    read_all();
    // R1: status is read-only
    wr(7'h00, 32'hFFFF_FFFF); rd(7'h00);
    // R4: wipe outside programming mode, control reads 0
    wr(7'h04, 32'h1); rd(7'h00); rd(7'h04);
    // R5: key write dropped, zeroized flag stays set
    wr(7'h14, 32'h1234_5678); rd(7'h00); rd(7'h14);
    // R6: word 8 dropped outside programming mode
    wr(7'h30, 32'hCAFE_0001); rd(7'h30);
    // R10: checksum write outside programming mode ignored
    wr(7'h0C, 32'h0); idle(12); rd(7'h00);
    // R2: wrong code, then the unlock code
    wr(7'h08, MAGIC ^ 32'h1); rd(7'h00); rd(7'h08);
    wr(7'h08, MAGIC); rd(7'h00);
    // R8: nonzero key clears the flag
    load_keys(32'h0102_0304); rd(7'h00);
    wr(7'h30, 32'hA5A5_0F0F); rd(7'h30); rd(7'h00);
    // R9: correct checksum
    wr(7'h0C, bench_crc(0)); idle(5); rd(7'h00); idle(5); rd(7'h00);
    // R9: wrong checksum
    wr(7'h0C, bench_crc(0) ^ 32'h8000_0000); idle(12); rd(7'h00);
    // R10: held key write and ignored restart during a check
    begin
      logic [31:0] good;
      good = bench_crc(0);
      wr(7'h0C, good);
      wr(7'h1C, 32'hDEAD_BEEF);
      wr(7'h18, 32'h7777_0000);
      wr(7'h0C, 32'h0);
      idle(12); rd(7'h00);
    end
    wr(7'h0C, bench_crc(0)); idle(12); rd(7'h00);
    // R7: lock and its stickiness
    wr(7'h4C, 32'h1); rd(7'h4C);
    wr(7'h30, 32'h1111_2222); rd(7'h30);
    wr(7'h4C, 32'h0); rd(7'h4C);
    // R8: wipe in programming mode, word 8 survives only in the readable variant
    wr(7'h04, 32'h1); rd(7'h00); rd(7'h30);
    wr(7'h0C, bench_crc(0)); idle(12); rd(7'h00);
    wr(7'h0C, 32'h1); idle(12); rd(7'h00);
    // R3: ordinary reset keeps key, mode and lock
    load_keys(32'h00F0_0F01);
    wr(7'h34, 32'h1); wr(7'h3C, 32'h0);
    @(negedge clk); rst_n = 0; bus_wr = 0; bus_rd = 0;
    repeat (2) @(negedge clk); rst_n = 1;
    read_all(); rd(7'h30);
    wr(7'h0C, bench_crc(0)); idle(12); rd(7'h00);
    // R11: error source, mask, slave error, clear
    rd(7'h48); idle(1); rd(7'h38);
    wr(7'h40, 32'h1); idle(2); rd(7'h3C);
    wr(7'h38, 32'h1); idle(1); rd(7'h38);
    wr(7'h34, 32'h1); rd(7'h50); rd(7'h05); idle(1);
    wr(7'h7C, 32'h9); idle(1);
    wr(7'h44, 32'h1); idle(1); rd(7'h3C); rd(7'h40); rd(7'h44);
    wr(7'h38, 32'h1); idle(1);
    // R12: power-on clears everything
    power_on();
    read_all(); rd(7'h30);
    // R8: word 8 alone clears the flag only in the write-only variant
    wr(7'h08, MAGIC); rd(7'h00);
    wr(7'h30, 32'h0000_00FF); rd(7'h00); rd(7'h30);
    idle(3);
    summary();
    $finish;
  end

endmodule